// File: doc/BRIEF.md
# Flash Command Sequencer with Embedded Program and Sector Erase

This block models the device side of a parallel flash memory. Host writes arrive on an asynchronous strobe bus with chip enable, write enable and output enable, all active low. The block samples this bus on its own clock and turns the write cycles into command sequences. A valid sequence starts an operation that times itself inside the device: a byte program, or an erase of one or more sectors. The host does not need to supply any further timing.

While an operation runs, the host learns its progress by polling bit 7 of the read data. A byte program shows the inverse of the written bit 7 until it finishes. A sector erase shows zero at any address in a selected sector until it finishes. Sector erase has a quiet window. Each further sector-select write made during the window adds that sector and restarts the window, and the erase itself begins only when the window runs out. After any write, reads are held off for a write recovery time.

After reset, the array is first cleared to all ones by an internal sweep, and the block then enters read mode.

Top module: `flash_emb_ctrl`

## Requirements
- R1: After reset, busy_o is 1 and dq_o is 0x00. The block then sweeps every byte of the array to 0xFF, which takes exactly 2^ADDR_W clocks, and afterwards enters read mode.
- R2: A program is four writes: 0xAA at address 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the target address and data byte. The target address is taken when write enable falls and the data when it rises. The stored byte becomes the old byte AND the data.
- R3: busy_o rises on the second clock after the clock that sees write enable rise on the final program write. It stays high for exactly PROG_CYC clocks.
- R4: While a program is busy, a read of the target address shows the inverse of the written bit 7 on dq_o[7]. Once it completes, the true stored byte is read.
- R5: All writes made while a program is busy are ignored. After completion the block is in read mode and accepts a new command sequence.
- R6: A sector erase is six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the sector. The sector is bits [ADDR_W-1 -: SECT_W] of the address. Every byte of each selected sector becomes 0xFF, and other sectors are left unchanged.
- R7: While an erase is pending or running, a read inside a selected sector returns 0x00, so dq_o[7] is 0. A read outside the selected sectors returns the stored data. After completion, dq_o[7] reads 1.
- R8: Each 0x30 write made during the quiet window adds its sector and restarts the window. busy_o then stays high for exactly ERASE_TO_CYC + 2^ADDR_W clocks, counted from the second clock after the last 0x30 write.
- R9: A 0xF0 write at any address returns the block to read mode and leaves the stored data unchanged. During the quiet window or a running erase, it aborts the erase and busy_o falls. An abort during the quiet window leaves the sector untouched.
- R10: A write that breaks the unlock prefix (wrong address or data) returns the block to read mode without any effect on the array.
- R11: For WREC_CYC clocks after each completed write, dq_o keeps its last value. Reads update it again only after that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| dq_o | output | 8 | Registered read data and poll status |
| busy_o | output | 1 | An embedded operation or erase window is active |

## Verification
The assertions check the following on every cycle:
- the write strobe is a single-cycle pulse;
- the program counter loads on entry to a program;
- program completion returns the block to read mode;
- an erase never waits with an empty sector set;
- a 0x30 write during the window restarts the countdown;
- dq_o is frozen during write recovery.

Only the bench scenarios can show the rest:
- the AND semantics of programming and the address/data latch edges;
- exact busy lengths;
- that writes during a program are ignored;
- that unselected sectors keep their data;
- that an abort in the window leaves data intact.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [3:0] {
    S_READ, S_UA, S_UB, S_PGM_ARM, S_ERS_A, S_ERS_B, S_ERS_C,
    S_PGM_BUSY, S_ERS_WAIT, S_ERS_RUN
  } fsm_e;

  localparam logic [10:0] UNLK_ADDR1 = 11'h555;
  localparam logic [10:0] UNLK_ADDR2 = 11'h2AA;
  localparam byte_t KEY1    = 8'hAA;
  localparam byte_t KEY2    = 8'h55;
  localparam byte_t OP_PROG = 8'hA0;
  localparam byte_t OP_ERS  = 8'h80;
  localparam byte_t OP_SECT = 8'h30;
  localparam byte_t OP_RST  = 8'hF0;
endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  byte_t             data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output byte_t             wr_data_o,
  output logic              rd_en_o
);
  logic we_q, armed_q, we_fall, we_rise;

  assign we_fall = we_q & ~we_ni & ~ce_ni;
  assign we_rise = ~we_q & we_ni & armed_q;
  assign rd_en_o = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b1;
      armed_q   <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      we_q     <= we_ni;
      wr_stb_o <= we_rise;
      if (we_fall) begin
        wr_addr_o <= addr_i;   // address on falling edge
        armed_q   <= 1'b1;
      end
      if (we_rise) begin
        wr_data_o <= data_i;   // data on rising edge
        armed_q   <= 1'b0;
      end
    end
  end

  a_r2_stb_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              set_en_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_en_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  input  byte_t             clr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output byte_t             rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  byte_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (set_en_i)      mem[set_addr_i] <= 8'hFF;
    else if (clr_en_i) mem[clr_addr_i] <= mem[clr_addr_i] & clr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECT_W       = 2,
  parameter int PROG_CYC     = 3200,
  parameter int ERASE_TO_CYC = 20000,
  parameter int WREC_CYC     = 1200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  byte_t             wr_data_i,
  output fsm_e              state_o,
  output logic              busy_o,
  output logic              rec_busy_o,
  output logic [(1<<SECT_W)-1:0] sect_mask_o,
  output logic              set_en_o,
  output logic [ADDR_W-1:0] set_addr_o,
  output logic              clr_en_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output byte_t             clr_data_o
);
  localparam int NSECT = 1 << SECT_W;
  localparam int MAXC  = (ERASE_TO_CYC > PROG_CYC) ? ERASE_TO_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int REC_W = $clog2(WREC_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  fsm_e              state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REC_W-1:0]  rec_q;
  logic [ADDR_W-1:0] ptr_q, paddr_q;
  byte_t             pdata_q;
  logic [NSECT-1:0]  mask_q, wr_sel;
  logic              at_a1, at_a2;

  assign at_a1  = wr_addr_i[10:0] == UNLK_ADDR1;
  assign at_a2  = wr_addr_i[10:0] == UNLK_ADDR2;
  assign wr_sel = NSECT'(1) << wr_addr_i[ADDR_W-1 -: SECT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rec_q <= '0;
    else if (wr_stb_i) rec_q <= REC_W'(WREC_CYC);
    else if (rec_q != '0) rec_q <= rec_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_ERS_RUN;   // power-up sweep to all ones
      mask_q  <= '1;
      ptr_q   <= '0;
      cnt_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      unique case (state_q)
        S_READ:  if (wr_stb_i && at_a1 && wr_data_i == KEY1) state_q <= S_UA;
        S_UA:    if (wr_stb_i) state_q <= (at_a2 && wr_data_i == KEY2) ? S_UB : S_READ;
        S_UB:    if (wr_stb_i) begin
          if (at_a1 && wr_data_i == OP_PROG)     state_q <= S_PGM_ARM;
          else if (at_a1 && wr_data_i == OP_ERS) state_q <= S_ERS_A;
          else                                   state_q <= S_READ;
        end
        S_PGM_ARM: if (wr_stb_i) begin
          paddr_q <= wr_addr_i;
          pdata_q <= wr_data_i;
          cnt_q   <= CNT_W'(PROG_CYC - 1);
          state_q <= S_PGM_BUSY;
        end
        S_ERS_A: if (wr_stb_i) state_q <= (at_a1 && wr_data_i == KEY1) ? S_ERS_B : S_READ;
        S_ERS_B: if (wr_stb_i) state_q <= (at_a2 && wr_data_i == KEY2) ? S_ERS_C : S_READ;
        S_ERS_C: if (wr_stb_i) begin
          if (wr_data_i == OP_SECT) begin
            mask_q  <= wr_sel;
            cnt_q   <= CNT_W'(ERASE_TO_CYC - 1);
            state_q <= S_ERS_WAIT;
          end else state_q <= S_READ;
        end
        S_PGM_BUSY: begin        // writes ignored
          if (cnt_q == '0) state_q <= S_READ;
          else cnt_q <= cnt_q - 1'b1;
        end
        S_ERS_WAIT: begin
          if (wr_stb_i && wr_data_i == OP_RST) begin
            mask_q  <= '0;
            state_q <= S_READ;
          end else if (wr_stb_i && wr_data_i == OP_SECT) begin
            mask_q <= mask_q | wr_sel;
            cnt_q  <= CNT_W'(ERASE_TO_CYC - 1);
          end else if (cnt_q == '0) begin
            ptr_q   <= '0;
            state_q <= S_ERS_RUN;
          end else cnt_q <= cnt_q - 1'b1;
        end
        S_ERS_RUN: begin
          ptr_q <= ptr_q + 1'b1;
          if ((wr_stb_i && wr_data_i == OP_RST) || ptr_q == LAST) begin
            mask_q  <= '0;
            state_q <= S_READ;
          end
        end
        default: state_q <= S_READ;
      endcase
    end
  end

  assign state_o     = state_q;
  assign busy_o      = state_q inside {S_PGM_BUSY, S_ERS_WAIT, S_ERS_RUN};
  assign rec_busy_o  = rec_q != '0;
  assign sect_mask_o = mask_q;
  assign set_en_o    = (state_q == S_ERS_RUN) && mask_q[ptr_q[ADDR_W-1 -: SECT_W]];
  assign set_addr_o  = ptr_q;
  assign clr_en_o    = (state_q == S_PGM_BUSY) && (cnt_q == '0);
  assign clr_addr_o  = paddr_q;
  assign clr_data_o  = pdata_q;

  a_r3_prog_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == S_PGM_BUSY) |-> cnt_q == CNT_W'(PROG_CYC - 1));
  a_r5_prog_done_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_o |=> state_q == S_READ);
  a_r6_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_ERS_WAIT |-> mask_q != '0);
  a_r8_window_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERS_WAIT && wr_stb_i && wr_data_i == OP_SECT)
      |=> (state_q == S_ERS_WAIT && cnt_q == CNT_W'(ERASE_TO_CYC - 1)));
endmodule

// File: rtl/flash_emb_ctrl.sv
module flash_emb_ctrl
  import flash_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECT_W       = 2,
  parameter int PROG_CYC     = 3200,
  parameter int ERASE_TO_CYC = 20000,
  parameter int WREC_CYC     = 1200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        dq_o,
  output logic              busy_o
);
  localparam int NSECT = 1 << SECT_W;

  logic              wr_stb, rd_en, rec_busy, set_en, clr_en;
  logic [ADDR_W-1:0] wr_addr, set_addr, clr_addr;
  byte_t             wr_data, clr_data, mem_rd, rd_val, dq_q;
  fsm_e              state;
  logic [NSECT-1:0]  mask;

  flash_bus_port #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_en_o(rd_en)
  );

  flash_cmd_seq #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .ERASE_TO_CYC(ERASE_TO_CYC), .WREC_CYC(WREC_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .state_o(state), .busy_o, .rec_busy_o(rec_busy), .sect_mask_o(mask),
    .set_en_o(set_en), .set_addr_o(set_addr),
    .clr_en_o(clr_en), .clr_addr_o(clr_addr), .clr_data_o(clr_data)
  );

  flash_cell_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i, .set_en_i(set_en), .set_addr_i(set_addr),
    .clr_en_i(clr_en), .clr_addr_i(clr_addr), .clr_data_i(clr_data),
    .rd_addr_i(addr_i), .rd_data_o(mem_rd)
  );

  always_comb begin
    rd_val = mem_rd;
    if (state == S_PGM_BUSY && addr_i == clr_addr)
      rd_val[7] = ~clr_data[7];
    else if ((state == S_ERS_WAIT || state == S_ERS_RUN) && mask[addr_i[ADDR_W-1 -: SECT_W]])
      rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dq_q <= '0;
    else if (rd_en && !rec_busy) dq_q <= rd_val;
  end

  assign dq_o = dq_q;

  a_r11_rec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_busy |=> $stable(dq_q));
endmodule

// File: tb/sim_flash_emb_ctrl.sv
`timescale 1ns/1ps
module sim_flash_emb_ctrl;
  localparam int AW = 11, SW = 2, PROG = 60, ETO = 200, WREC = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0, dq;
  logic busy;
  int n_chk = 0, n_fail = 0, bcnt;
  logic [7:0] rv;
  logic [7:0] ref_mem [DEPTH];

  always #2.5 clk = ~clk;

  flash_emb_ctrl #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PROG),
    .ERASE_TO_CYC(ETO), .WREC_CYC(WREC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .dq_o(dq), .busy_o(busy));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; data = ~d;
    @(negedge clk); we_n = 1; data = d; addr = ~a;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk); d = dq; ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, ref_mem[a]);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic settle();
    int n;
    count_busy(n);
    repeat (WREC + 2) @(negedge clk);
  endtask

  task automatic prog_cmd(input logic [AW-1:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
    ref_mem[a] = ref_mem[a] & d;
  endtask

  task automatic ers_cmd(input logic [AW-1:0] a);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(a, 8'h30);
  endtask

  task automatic ref_erase(input int s);
    for (int i = 0; i < DEPTH; i++)
      if ((i >> (AW - SW)) == s) ref_mem[i] = 8'hFF;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state and init sweep
    chk("R1 busy after reset", busy, 1);
    chk("R1 dq after reset", dq, 0);
    count_busy(bcnt);
    chk("R1 sweep length", bcnt, DEPTH);
    rd_chk("R1 erased low", 11'h000);
    rd_chk("R1 erased high", 11'h7FF);

    // R2/R3 program, latch edges, busy length
    prog_cmd(11'h123, 8'h5A);
    count_busy(bcnt);
    chk("R3 program busy length", bcnt, PROG);
    settle();
    rd_chk("R2 programmed byte", 11'h123);
    prog_cmd(11'h123, 8'hF0);
    settle();
    rd_chk("R2 AND semantics", 11'h123);

    // R4 polling during program
    prog_cmd(11'h0AB, 8'h3C);
    repeat (WREC + 2) @(negedge clk);
    rd(11'h0AB, rv);
    chk("R4 poll bit inverted", rv[7], 1);
    chk("R4 busy while polling", busy, 1);
    settle();
    rd(11'h0AB, rv);
    chk("R4 true data after done", rv, 8'h3C);

    // R5 writes ignored while programming
    prog_cmd(11'h050, 8'h11);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h060, 8'h00);
    settle();
    rd_chk("R5 target programmed", 11'h050);
    rd_chk("R5 ignored write no effect", 11'h060);
    prog_cmd(11'h070, 8'h77);
    settle();
    rd_chk("R5 new sequence accepted", 11'h070);

    // R9 reset in read mode
    wr(11'h123, 8'hF0);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R9 reset keeps data", 11'h123);

    // R10 broken prefix
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h54); wr(11'h555, 8'hA0); wr(11'h010, 8'h00);
    chk("R10 no busy", busy, 0);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R10 array untouched", 11'h010);

    // R6 single sector erase
    prog_cmd(11'h205, 8'h12); settle();
    prog_cmd(11'h407, 8'h34); settle();
    ers_cmd(11'h210);
    count_busy(bcnt);
    chk("R6 erase busy length", bcnt, ETO + DEPTH);
    ref_erase(1);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R6 selected erased", 11'h205);
    rd_chk("R6 other sector kept", 11'h407);
    rd_chk("R6 sector0 kept", 11'h123);

    // R7/R8 polling and window restart
    prog_cmd(11'h005, 8'h66); settle();
    prog_cmd(11'h605, 8'h77); settle();
    ers_cmd(11'h005);
    repeat (30) @(negedge clk);
    rd(11'h005, rv);
    chk("R7 erasing sector reads zero", rv, 0);
    rd_chk("R7 outside sector data", 11'h407);
    wr(11'h600, 8'h30);
    count_busy(bcnt);
    chk("R8 restarted window length", bcnt, ETO + DEPTH);
    ref_erase(0); ref_erase(3);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R8 first sector erased", 11'h005);
    rd_chk("R8 added sector erased", 11'h605);
    rd_chk("R8 unselected kept", 11'h407);
    rd(11'h005, rv);
    chk("R7 D7 one when done", rv[7], 1);

    // R9 abort in quiet window
    ers_cmd(11'h407);
    repeat (20) @(negedge clk);
    wr(11'h000, 8'hF0);
    chk("R9 abort window busy low", busy, 0);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R9 window abort keeps data", 11'h407);

    // R9 abort in running erase (sector 3 contents undefined afterwards)
    ers_cmd(11'h600);
    repeat (ETO + 100) @(negedge clk);
    chk("R9 erase running", busy, 1);
    wr(11'h000, 8'hF0);
    chk("R9 abort run busy low", busy, 0);
    repeat (WREC + 2) @(negedge clk);
    prog_cmd(11'h070, 8'h07);
    settle();
    rd_chk("R9 read mode after abort", 11'h070);

    // R11 write recovery hold
    rd_chk("R11 prior read", 11'h407);
    wr(11'h000, 8'hF0);
    rd(11'h123, rv);
    chk("R11 stale during recovery", rv, ref_mem[11'h407]);
    repeat (WREC + 2) @(negedge clk);
    rd_chk("R11 updated after recovery", 11'h123);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule